// File: doc/BRIEF.md
# Two-Phase-On Step Sequencer

This block turns a step pulse stream and a direction input into the four phase-select lines of a unipolar stepper drive. Its output pattern always has one winding of each phase pair on, so that two phases are energised at all times. The pattern moves through four states per electrical cycle, 90 electrical degrees apart. The order of the states depends only on the direction input.

Micro-stepping is handled by a counter that sits in front of the pattern. Every rising edge on the step input is one micro-step. The pattern moves only after the number of micro-steps that the selected mode asks for, and that number may be 5 or 10 as well as a power of two. The counter value is brought out as a micro-step index, which a separate reference-waveform generator uses to shape the coil current. Reversing the direction walks the counter back down, and it borrows from the pattern at zero. This keeps the electrical position consistent across a reversal.

Top module: `stepseq_top`

## Requirements
- R1: After reset, phase_o is 4'b1001 and ustep_o is 0.
- R2: phase_o carries A on bit 3, A\ on bit 2, B on bit 1 and B\ on bit 0. With dir_i high the pattern advances 1001 -> 0101 -> 0110 -> 1010 and then returns to 1001.
- R3: With dir_i low the pattern steps 1001 -> 1010 -> 0110 -> 0101 and then returns to 1001.
- R4: Bits 3 and 2 of phase_o are never both high, and bits 1 and 0 are never both high. Exactly two bits of phase_o are high at all times, so a single-phase pattern never appears.
- R5: mode_i sets the micro-steps per pattern change N: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, 4 gives 16, 5 gives 5, 6 gives 10, and 7 is treated as 1. The pattern changes after exactly N step edges taken in one direction.
- R6: With dir_i high, each step edge raises ustep_o by one. A step edge taken at N-1 sets ustep_o to 0 and advances the pattern in the same clock cycle.
- R7: With dir_i low, each step edge lowers ustep_o by one. A step edge taken at 0 sets ustep_o to N-1 and moves the pattern back one state. Any number of reverse steps exactly undoes the same number of forward steps.
- R8: Only a rising edge of step_i counts. While step_i is held high or held low, ustep_o and phase_o keep their values.
- R9: While ustep_o is 0, N comes from mode_i directly. While ustep_o is not 0, N keeps the value it had when ustep_o was last 0, so a mode change takes effect only at a pattern boundary.
- R10: phase_o changes only on a clock cycle in which a step edge carries or borrows across a pattern boundary. When it does change, exactly one phase pair swaps its two bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Step pulse; each rising edge is one micro-step |
| dir_i | input | 1 | Direction: 1 forward, 0 reverse |
| mode_i | input | 3 | Micro-step mode code (see R5) |
| phase_o | output | 4 | Phase selects {A, A\, B, B\} |
| ustep_o | output | CNT_W (4) | Micro-step index within the current pattern state |

## Verification
The assertions assume that step_i is already synchronous to clk when SYNC_STAGES is 0. They also assume that dir_i and mode_i do not change in the same clock cycle as a rising step edge. The bench meets both assumptions by changing dir_i and mode_i only on falling clock edges. It always lets at least one clock with step_i low pass between two pulses, and it changes mode_i only in a cycle with no step edge. Random traffic mixes short forward and reverse runs with mode changes at arbitrary counter values, including the unused code 7. Directed cases cover a mode change in mid-pattern, a held step level, and the wrap in each direction.

// File: rtl/stepseq_pkg.sv
package stepseq_pkg;

   localparam int unsigned MODE_W = 3;
   localparam int unsigned MAX_N  = 16;

   // Micro-steps per pattern change for each mode code
   function automatic int unsigned mode_div(input logic [MODE_W-1:0] code);
      case (code)
         3'd0:    return 1;
         3'd1:    return 2;
         3'd2:    return 4;
         3'd3:    return 8;
         3'd4:    return 16;
         3'd5:    return 5;
         3'd6:    return 10;
         default: return 1;
      endcase
   endfunction

   // Pattern index -> {A, A\, B, B\}
   function automatic logic [3:0] pattern_of(input logic [1:0] idx);
      case (idx)
         2'd0:    return 4'b1001;
         2'd1:    return 4'b0101;
         2'd2:    return 4'b0110;
         default: return 4'b1010;
      endcase
   endfunction

endpackage

// File: rtl/stepseq_edge.sv
module stepseq_edge #(
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step_i,
   output logic rise_o
);

   logic step_s;
   logic step_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign step_s = step_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else if (SYNC_STAGES == 1) chain <= step_i;
            else chain <= {chain[SYNC_STAGES-2:0], step_i};
         end
         assign step_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) step_q <= 1'b0;
      else        step_q <= step_s;
   end

   assign rise_o = step_s & ~step_q;

   // R8
   no_double_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);

endmodule

// File: rtl/stepseq_ucount.sv
module stepseq_ucount
   import stepseq_pkg::*;
#(
   parameter int unsigned MAX_DIV = 16,
   localparam int unsigned CNT_W  = $clog2(MAX_DIV),
   localparam int unsigned DIV_W  = $clog2(MAX_DIV + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise_i,
   input  logic              dir_i,
   input  logic [MODE_W-1:0] mode_i,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              carry_o,
   output logic              borrow_o
);

   logic [DIV_W-1:0] act_div;
   logic [DIV_W-1:0] div_now;
   logic [CNT_W-1:0] last_now;
   logic             at_zero;
   logic             at_last;

   generate
      if (MAX_DIV < MAX_N) begin : g_bad_div
         $error("stepseq_ucount: MAX_DIV must be at least 16");
      end
   endgenerate

   assign at_zero  = (cnt_o == '0);
   assign div_now  = at_zero ? DIV_W'(mode_div(mode_i)) : act_div;
   assign last_now = CNT_W'(div_now - 1'b1);
   assign at_last  = (cnt_o == last_now);

   assign carry_o  = rise_i &  dir_i & at_last;
   assign borrow_o = rise_i & ~dir_i & at_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_div <= DIV_W'(1);
      end else if (at_zero) begin
         act_div <= DIV_W'(mode_div(mode_i));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o <= '0;
      end else if (rise_i) begin
         if (dir_i) cnt_o <= at_last ? '0 : cnt_o + 1'b1;
         else       cnt_o <= at_zero ? last_now : cnt_o - 1'b1;
      end
   end

   // R5
   cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_o != '0) |-> ({1'b0, cnt_o} < act_div));

   // R8
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rise_i |=> $stable(cnt_o));

   // R6
   carry_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      carry_o |=> (cnt_o == '0));

   // R9
   div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt_o != '0) && !rise_i) |=> $stable(act_div));

endmodule

// File: rtl/stepseq_phase.sv
module stepseq_phase
   import stepseq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       adv_i,
   input  logic       ret_i,
   output logic [3:0] phase_o
);

   logic [1:0] idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     idx <= 2'd0;
      else if (adv_i) idx <= idx + 2'd1;
      else if (ret_i) idx <= idx - 2'd1;
   end

   assign phase_o = pattern_of(idx);

   // R4
   pair_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(phase_o[3] && phase_o[2]) && !(phase_o[1] && phase_o[0]));

   // R4
   two_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(phase_o) == 2);

   // R10
   phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(adv_i || ret_i) |=> $stable(phase_o));

   // R10
   one_pair_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i || ret_i) |=> ($countones(phase_o ^ $past(phase_o)) == 2));

   // R2
   adv_ret_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(adv_i && ret_i));

endmodule

// File: rtl/stepseq_top.sv
module stepseq_top
   import stepseq_pkg::*;
#(
   parameter int unsigned MAX_DIV     = 16,
   parameter int unsigned SYNC_STAGES = 0,
   localparam int unsigned CNT_W      = $clog2(MAX_DIV)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   input  logic              dir_i,
   input  logic [MODE_W-1:0] mode_i,
   output logic [3:0]        phase_o,
   output logic [CNT_W-1:0]  ustep_o
);

   logic rise;
   logic carry;
   logic borrow;

   stepseq_edge #(
      .SYNC_STAGES(SYNC_STAGES)
   ) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (step_i),
      .rise_o (rise)
   );

   stepseq_ucount #(
      .MAX_DIV(MAX_DIV)
   ) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .rise_i   (rise),
      .dir_i    (dir_i),
      .mode_i   (mode_i),
      .cnt_o    (ustep_o),
      .carry_o  (carry),
      .borrow_o (borrow)
   );

   stepseq_phase u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv_i   (carry),
      .ret_i   (borrow),
      .phase_o (phase_o)
   );

   // R10
   boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o != $past(phase_o)) |-> ($past(ustep_o) == '0 || ustep_o == '0));

endmodule

// File: tb/stepseq_top_tb.sv
module stepseq_top_tb;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       step_i = 1'b0;
   logic       dir_i = 1'b1;
   logic [2:0] mode_i = 3'd0;
   logic [3:0] phase_o;
   logic [3:0] ustep_o;

   int checks = 0;
   int errors = 0;

   int e_idx = 0;
   int e_cnt = 0;
   int e_div = 1;

   always #(CLK_PERIOD/2) clk = ~clk;

   stepseq_top u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_i  (step_i),
      .dir_i   (dir_i),
      .mode_i  (mode_i),
      .phase_o (phase_o),
      .ustep_o (ustep_o)
   );

   function automatic int div_of(input logic [2:0] m);
      case (m)
         3'd1: return 2;
         3'd2: return 4;
         3'd3: return 8;
         3'd4: return 16;
         3'd5: return 5;
         3'd6: return 10;
         default: return 1;
      endcase
   endfunction

   function automatic logic [3:0] pat_of(input int i);
      case (i & 3)
         0: return 4'b1001;
         1: return 4'b0101;
         2: return 4'b0110;
         default: return 4'b1010;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [3:0] got_ph, input logic [3:0] exp_ph,
                      input int got_u, input int exp_u);
      checks++;
      if (got_ph !== exp_ph || got_u != exp_u) begin
         errors++;
         $display("FAIL %s: phase=%b ustep=%0d expected phase=%b ustep=%0d",
                  tag, got_ph, got_u, exp_ph, exp_u);
      end
      checks++;
      if ($countones(got_ph) != 2 || (got_ph[3] & got_ph[2]) || (got_ph[1] & got_ph[0])) begin
         errors++;
         $display("FAIL R4: phase=%b expected two bits, one per pair", got_ph);
      end
   endtask

   task automatic model_step(input logic d);
      if (e_cnt == 0) e_div = div_of(mode_i);
      if (d) begin
         if (e_cnt == e_div - 1) begin e_cnt = 0; e_idx = e_idx + 1; end
         else e_cnt = e_cnt + 1;
      end else begin
         if (e_cnt == 0) begin e_cnt = e_div - 1; e_idx = e_idx + 3; end
         else e_cnt = e_cnt - 1;
      end
   endtask

   task automatic do_step(input logic d, input string tag);
      @(negedge clk);
      dir_i  = d;
      step_i = 1'b1;
      @(negedge clk);
      step_i = 1'b0;
      model_step(d);
      chk(tag, phase_o, pat_of(e_idx), int'(ustep_o), e_cnt);
   endtask

   task automatic set_mode(input logic [2:0] m);
      @(negedge clk);
      mode_i = m;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [3:0] fwd_exp [4];
      logic [3:0] ph_hold;
      int         u_hold;
      void'($urandom(32'd24680));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", phase_o, 4'b1001, int'(ustep_o), 0);

      // R2 forward full-step order with wrap, mode code 0
      fwd_exp = '{4'b0101, 4'b0110, 4'b1010, 4'b1001};
      for (int i = 0; i < 4; i++) begin
         do_step(1'b1, "R2");
         checks++;
         if (phase_o !== fwd_exp[i]) begin
            errors++;
            $display("FAIL R2: phase=%b expected %b", phase_o, fwd_exp[i]);
         end
      end

      // R3 reverse order with wrap
      for (int i = 0; i < 4; i++) do_step(1'b0, "R3");

      // R5 mode 5 -> N=5; R6 count up and carry
      set_mode(3'd5);
      for (int i = 0; i < 10; i++) do_step(1'b1, "R5_R6");
      // R7 reverse undoes the forward run, including borrow
      for (int i = 0; i < 12; i++) do_step(1'b0, "R7");
      for (int i = 0; i < 2; i++) do_step(1'b1, "R7");

      // R5 code 7 treated as N=1
      set_mode(3'd7);
      for (int i = 0; i < 3; i++) do_step(1'b1, "R5");

      // R9 mode change in mid-pattern waits for boundary
      set_mode(3'd4);
      for (int i = 0; i < 3; i++) do_step(1'b1, "R9");
      set_mode(3'd5);
      for (int i = 0; i < 18; i++) do_step(1'b1, "R9");

      // R8 step held high counts once, then held low has no effect
      @(negedge clk);
      dir_i = 1'b1;
      step_i = 1'b1;
      @(negedge clk);
      model_step(1'b1);
      ph_hold = phase_o;
      u_hold = int'(ustep_o);
      repeat (5) @(negedge clk);
      chk("R8", phase_o, pat_of(e_idx), int'(ustep_o), e_cnt);
      step_i = 1'b0;
      repeat (5) @(negedge clk);
      chk("R8", phase_o, ph_hold, int'(ustep_o), u_hold);

      // R10 mode 6 -> N=10, phase changes only at boundaries
      set_mode(3'd6);
      for (int i = 0; i < 25; i++) do_step(1'b1, "R10");

      // Random runs
      for (int i = 0; i < 600; i++) begin
         if (($urandom % 16) == 0) set_mode(3'($urandom % 8));
         do_step(1'($urandom % 2), "R6_R7_rand");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule